// File: doc/BRIEF.md
# USB Device Address and Endpoint Status Registers

This block is the register file that a small 8-bit controller uses to steer a low-speed USB serial interface engine (SIE). It keeps the device address and its enable, one mode register for each of three endpoints, and a sticky flag that records bus activity. The SIE feeds it single-cycle strobes: a decoded token with its kind, address and endpoint number, a completed handshake on an endpoint, any non-idle bus event, and a bus reset. In return it tells the SIE, within the same cycle, whether a token is meant for this device. It also presents the 4-bit mode field of every endpoint.

Firmware reads and writes the registers through a simple synchronous byte bus. Read data is combinational from the offset. The status flags follow one rule throughout: the SIE sets them, firmware clears a flag by writing 0 to it, and writing 1 leaves the flag as it is. When a set and a clear land on the same bit in the same cycle, the set wins, so no event is ever lost.

Top module: `usb_devreg_file`

## Requirements
- R1: After reset every register reads 0, `ep_mode` is 0 and `tok_accept` is low.
- R2: Offset 0x11 bit 0 is the activity flag. An `sie_activity` strobe sets it at the next clock edge. A firmware write with bit 0 = 0 clears it, and a write with bit 0 = 1 keeps it. A set and a clear in the same cycle leave it set. The other bits of 0x11 read 0.
- R3: Offset 0x10 is the address register: bit 7 is the enable and bits [6:0] are the device address. All eight bits can be read and written.
- R4: `tok_accept` is high in the same cycle as `sie_tok_valid` only when the enable is 1, `sie_tok_addr` equals the stored address, `sie_tok_ep` is 0, 1 or 2, and the token kind is valid. The kind encoding is 0 = OUT, 1 = IN, 2 = SETUP and 3 = no token.
- R5: An `sie_bus_reset` strobe clears the address register at the next edge. It wins over a firmware write to 0x10 in the same cycle, and it leaves the endpoint registers unchanged.
- R6: Offset 0x12 is the endpoint 0 register. An accepted token to endpoint 0 sets bit 7 for SETUP, bit 6 for IN or bit 5 for OUT, and leaves the other two flags unchanged. These flags follow the write-0-clears, write-1-keeps rule, and a set wins over a clear in the same cycle.
- R7: A token that is not accepted, a token to endpoint 1 or 2, and a token to an endpoint above 2 leave the endpoint 0 flags unchanged. A token to an endpoint above 2 is never accepted.
- R8: Offsets 0x14 and 0x16 are the endpoint 1 and 2 registers. Their bits [7:5] read 0 and ignore writes.
- R9: Bit 4 of each endpoint register is the handshake flag. `sie_ack_valid` with `sie_ack_ep` = k (k ≤ 2) sets it in endpoint k. Firmware clears it with the write-0 rule, and a set wins over a clear. An `sie_ack_ep` above 2 has no effect.
- R10: Bits [3:0] of each endpoint register are a read/write mode field. It appears on `ep_mode[4k+3:4k]` for endpoint k from the clock edge that writes it.
- R11: Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Firmware write strobe |
| bus_addr | input | 8 | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| sie_tok_valid | input | 1 | Token decoded this cycle |
| sie_tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 none |
| sie_tok_addr | input | 7 | Device address field of the token |
| sie_tok_ep | input | 4 | Endpoint field of the token |
| sie_ack_valid | input | 1 | A transaction completed with a handshake |
| sie_ack_ep | input | 4 | Endpoint of that transaction |
| sie_activity | input | 1 | Non-idle bus event seen |
| sie_bus_reset | input | 1 | USB bus reset detected |
| tok_accept | output | 1 | Token is addressed to this enabled device |
| ep_mode | output | 12 | Mode fields, 4 bits per endpoint, endpoint 0 lowest |

## Verification
A wrong stored address or enable shows up as a wrong `tok_accept` on the first token after the error. It also shows up on the next read of 0x10. A sticky flag that is lost, set by the wrong event, or cleared by a write of 1 is visible in the next read of its register. A mode field that is written to the wrong endpoint appears on `ep_mode` one cycle after the write. The bench mixes random traffic with directed collisions of set and clear, bus reset against write, and out-of-range endpoints. It compares every read, `tok_accept` and `ep_mode` every cycle, so most faults are reported within one cycle of when they could first be seen.

// File: rtl/usbreg_pkg.sv
// Package: shared constants and types for the USB device register file.
// Assumes a byte-wide firmware bus and exactly three endpoints.
package usbreg_pkg;
    localparam int DATA_W     = 8;
    localparam int BUS_AW     = 8;
    localparam int DEV_ADDR_W = 7;
    localparam int EP_W       = 4;
    localparam int MODE_W     = 4;
    localparam int NUM_EP     = 3;
    localparam int NUM_FLAGS  = 3;

    // Bit positions inside an endpoint register.
    localparam int ACK_BIT    = 4;
    localparam int FLAG_LSB   = 5;

    // Register offsets.
    localparam logic [BUS_AW-1:0] OFS_DEVADDR  = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_ACTIVITY = 8'h11;
    localparam logic [BUS_AW-1:0] OFS_EP_BASE  = 8'h12;
    localparam int                OFS_EP_STEP  = 2;

    // Token kind as delivered by the SIE.
    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2,
        TOK_NONE  = 2'd3
    } tok_kind_e;
endpackage

// File: rtl/usbreg_sticky.sv
// Module: usbreg_sticky
// A bank of W event flags. A set pulse raises a bit, a clear pulse drops it,
// and a set arriving together with a clear wins. Assumes single-cycle pulses.
module usbreg_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: hold one flag with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else
                q[i] <= set[i] | (q[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/usbreg_tok_filter.sv
// Module: usbreg_tok_filter
// Decides whether an SIE token belongs to this device and turns token and
// handshake strobes into per-endpoint set pulses. Purely combinational.
// Assumes the stored address and enable are registered elsewhere.
module usbreg_tok_filter
    import usbreg_pkg::*;
#(
    parameter int N_EP   = NUM_EP,
    parameter int EPW    = EP_W,
    parameter int ADDR_W = DEV_ADDR_W
) (
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              dev_en,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              ack_valid,
    input  logic [EPW-1:0]    ack_ep,
    output logic              accept,
    output logic [2:0]        ep0_flag_set,
    output logic [N_EP-1:0]   ack_hit
);
    logic ep_in_range;
    logic kind_ok;
    logic to_ep0;

    // Purpose: qualify the token against enable, address, endpoint and kind.
    always_comb begin
        ep_in_range = (tok_ep < EPW'(N_EP));
        kind_ok     = (tok_kind != TOK_NONE);
        accept      = tok_valid && dev_en && (tok_addr == dev_addr)
                      && ep_in_range && kind_ok;
        to_ep0      = accept && (tok_ep == '0);
    end

    // Purpose: pick the endpoint 0 flag that matches the token kind.
    always_comb begin
        ep0_flag_set[2] = to_ep0 && (tok_kind == TOK_SETUP);
        ep0_flag_set[1] = to_ep0 && (tok_kind == TOK_IN);
        ep0_flag_set[0] = to_ep0 && (tok_kind == TOK_OUT);
    end

    for (genvar k = 0; k < N_EP; k++) begin : g_ack
        // Purpose: route a handshake strobe to its endpoint.
        assign ack_hit[k] = ack_valid && (ack_ep == EPW'(k));
    end
endmodule

// File: rtl/usbreg_ep_reg.sv
// Module: usbreg_ep_reg
// One endpoint register: a 4-bit mode field, a sticky handshake flag in bit 4,
// and, when HAS_FLAGS is set, three sticky token flags in bits [7:5].
// Without HAS_FLAGS those bits read 0. Flags clear on a write of 0.
module usbreg_ep_reg
    import usbreg_pkg::*;
#(
    parameter bit HAS_FLAGS = 1'b0,
    parameter int MW        = MODE_W,
    parameter int DW        = DATA_W,
    parameter int NF        = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_wr,
    input  logic [DW-1:0] wdata,
    input  logic [NF-1:0] flag_set,
    input  logic          ack_set,
    output logic [DW-1:0] reg_val,
    output logic [MW-1:0] mode
);
    logic          ack_q;
    logic [NF-1:0] flags_q;

    // Purpose: firmware-owned mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (sel_wr)
            mode <= wdata[MW-1:0];
    end

    usbreg_sticky #(.W(1)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ack_set),
        .clr   (sel_wr & ~wdata[ACK_BIT]),
        .q     (ack_q)
    );

    if (HAS_FLAGS) begin : g_flags
        usbreg_sticky #(.W(NF)) u_tok (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set),
            .clr   ({NF{sel_wr}} & ~wdata[FLAG_LSB +: NF]),
            .q     (flags_q)
        );
    end else begin : g_noflags
        logic unused_inputs;
        assign unused_inputs = ^{flag_set, wdata[FLAG_LSB +: NF]};
        assign flags_q       = '0;
    end

    // Purpose: assemble the read view of the register.
    always_comb begin
        reg_val                  = '0;
        reg_val[MW-1:0]          = mode;
        reg_val[ACK_BIT]         = ack_q;
        reg_val[FLAG_LSB +: NF]  = flags_q;
    end
endmodule

// File: rtl/usb_devreg_file.sv
// Module: usb_devreg_file
// Firmware register file for a low-speed USB device: address and enable,
// a sticky activity flag, and three endpoint registers. Accepts SIE event
// strobes and returns the token accept and the endpoint modes.
// Assumes single-cycle SIE strobes and a synchronous firmware bus.
module usb_devreg_file
    import usbreg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [BUS_AW-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     sie_tok_valid,
    input  logic [1:0]               sie_tok_kind,
    input  logic [DEV_ADDR_W-1:0]    sie_tok_addr,
    input  logic [EP_W-1:0]          sie_tok_ep,
    input  logic                     sie_ack_valid,
    input  logic [EP_W-1:0]          sie_ack_ep,
    input  logic                     sie_activity,
    input  logic                     sie_bus_reset,
    output logic                     tok_accept,
    output logic [NUM_EP*MODE_W-1:0] ep_mode
);
    logic [DATA_W-1:0]    devaddr_q;
    logic                 dev_en;
    logic                 act_q;
    logic                 wr_devaddr;
    logic                 wr_activity;
    logic [2:0]           ep0_flag_set;
    logic [NUM_EP-1:0]    ack_hit;
    logic [DATA_W-1:0]    ep_val [NUM_EP];

    // Purpose: decode firmware writes to the fixed registers.
    always_comb begin
        wr_devaddr  = bus_wr && (bus_addr == OFS_DEVADDR);
        wr_activity = bus_wr && (bus_addr == OFS_ACTIVITY);
    end

    // Purpose: address register; bus reset has priority over firmware.
    always_ff @(posedge clk) begin
        if (!rst_n)
            devaddr_q <= '0;
        else if (sie_bus_reset)
            devaddr_q <= '0;
        else if (wr_devaddr)
            devaddr_q <= bus_wdata;
    end

    assign dev_en = devaddr_q[DATA_W-1];

    usbreg_sticky #(.W(1)) u_activity (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (sie_activity),
        .clr   (wr_activity & ~bus_wdata[0]),
        .q     (act_q)
    );

    usbreg_tok_filter #(
        .N_EP   (NUM_EP),
        .EPW    (EP_W),
        .ADDR_W (DEV_ADDR_W)
    ) u_filter (
        .tok_valid    (sie_tok_valid),
        .tok_kind     (sie_tok_kind),
        .tok_addr     (sie_tok_addr),
        .tok_ep       (sie_tok_ep),
        .dev_en       (dev_en),
        .dev_addr     (devaddr_q[DEV_ADDR_W-1:0]),
        .ack_valid    (sie_ack_valid),
        .ack_ep       (sie_ack_ep),
        .accept       (tok_accept),
        .ep0_flag_set (ep0_flag_set),
        .ack_hit      (ack_hit)
    );

    for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
        localparam logic [BUS_AW-1:0] EP_OFS = BUS_AW'(OFS_EP_BASE + OFS_EP_STEP * k);
        logic [NUM_FLAGS-1:0] flag_set;
        logic                 sel_wr;

        assign flag_set = (k == 0) ? ep0_flag_set : '0;
        assign sel_wr   = bus_wr && (bus_addr == EP_OFS);

        usbreg_ep_reg #(
            .HAS_FLAGS (k == 0),
            .MW        (MODE_W),
            .DW        (DATA_W),
            .NF        (NUM_FLAGS)
        ) u_ep (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_wr   (sel_wr),
            .wdata    (bus_wdata),
            .flag_set (flag_set),
            .ack_set  (ack_hit[k]),
            .reg_val  (ep_val[k]),
            .mode     (ep_mode[k*MODE_W +: MODE_W])
        );
    end

    // Purpose: combinational read multiplexer; unmapped offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_DEVADDR)
            bus_rdata = devaddr_q;
        if (bus_addr == OFS_ACTIVITY)
            bus_rdata = {{(DATA_W-1){1'b0}}, act_q};
        for (int k = 0; k < NUM_EP; k++) begin
            if (bus_addr == BUS_AW'(OFS_EP_BASE + OFS_EP_STEP * k))
                bus_rdata = ep_val[k];
        end
    end
endmodule

// File: rtl/usbreg_checker.sv
// Module: usbreg_checker
// Temporal checks for usb_devreg_file, bound to every instance of it.
module usbreg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sie_activity,
    input logic       sie_bus_reset,
    input logic       sie_tok_valid,
    input logic       sie_ack_valid,
    input logic [3:0] sie_ack_ep,
    input logic       tok_accept,
    input logic       act_q,
    input logic       dev_en,
    input logic [7:0] ep0_val,
    input logic [7:0] ep1_val
);
    AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sie_activity |=> act_q); // R2
    AST_ACT_ONLY_SIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> $past(sie_activity)); // R2
    AST_ACCEPT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tok_accept |-> (dev_en && sie_tok_valid)); // R4
    AST_BUSRST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sie_bus_reset |=> !tok_accept); // R5
    AST_EP0_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ep0_val[7]) |-> $past(tok_accept)); // R6
    AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_ack_valid && sie_ack_ep == 4'd1) |=> ep1_val[4]); // R9
endmodule

bind usb_devreg_file usbreg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sie_activity  (sie_activity),
    .sie_bus_reset (sie_bus_reset),
    .sie_tok_valid (sie_tok_valid),
    .sie_ack_valid (sie_ack_valid),
    .sie_ack_ep    (sie_ack_ep),
    .tok_accept    (tok_accept),
    .act_q         (act_q),
    .dev_en        (dev_en),
    .ep0_val       (ep_val[0]),
    .ep1_val       (ep_val[1])
);

// File: tb/tb_usb_devreg_file.sv
`timescale 1ns/1ps
module tb_usb_devreg_file;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic        sie_tok_valid;
    logic [1:0]  sie_tok_kind;
    logic [6:0]  sie_tok_addr;
    logic [3:0]  sie_tok_ep;
    logic        sie_ack_valid;
    logic [3:0]  sie_ack_ep;
    logic        sie_activity, sie_bus_reset;
    logic        tok_accept;
    logic [11:0] ep_mode;

    always #10 clk = ~clk;

    usb_devreg_file dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    logic [7:0] m_dev;
    logic       m_act;
    logic [7:0] m_ep [3];

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h10: return m_dev;
            8'h11: return {7'b0, m_act};
            8'h12: return m_ep[0];
            8'h14: return m_ep[1];
            8'h16: return m_ep[2];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10: return "R3,R5";
            8'h11: return "R2";
            8'h12: return "R6,R7,R9";
            8'h14, 8'h16: return "R8,R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic m_accept(input logic tv, input logic [1:0] tk,
                                      input logic [6:0] ta, input logic [3:0] te);
        return tv && m_dev[7] && (ta == m_dev[6:0]) && (te < 4'd3) && (tk != 2'd3);
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare outputs against the model, advance model.
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] wd,
                         input logic tv, input logic [1:0] tk, input logic [6:0] ta,
                         input logic [3:0] te, input logic av, input logic [3:0] ae,
                         input logic act, input logic brst);
        logic acc;
        logic [7:0] ne;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = wd;
        sie_tok_valid = tv; sie_tok_kind = tk; sie_tok_addr = ta; sie_tok_ep = te;
        sie_ack_valid = av; sie_ack_ep = ae; sie_activity = act; sie_bus_reset = brst;
        #1;
        acc = m_accept(tv, tk, ta, te);
        check((te > 4'd2) ? "R7" : "R4", tok_accept, acc, "tok_accept");
        check(tag_of(a), bus_rdata, m_read(a), $sformatf("read %0h", a));
        check("R10", ep_mode, {m_ep[2][3:0], m_ep[1][3:0], m_ep[0][3:0]}, "ep_mode");
        @(posedge clk);
        if (brst) m_dev = 8'h00;
        else if (wr && a == 8'h10) m_dev = wd;
        m_act = act | (m_act & !(wr && a == 8'h11 && !wd[0]));
        for (int k = 0; k < 3; k++) begin
            logic sel;
            sel = wr && (a == 8'(8'h12 + 2 * k));
            ne = m_ep[k];
            if (sel) ne[3:0] = wd[3:0];
            ne[4] = (av && ae == 4'(k)) | (m_ep[k][4] & !(sel && !wd[4]));
            if (k == 0) begin
                ne[7] = (acc && te == 0 && tk == 2'd2) | (m_ep[0][7] & !(sel && !wd[7]));
                ne[6] = (acc && te == 0 && tk == 2'd1) | (m_ep[0][6] & !(sel && !wd[6]));
                ne[5] = (acc && te == 0 && tk == 2'd0) | (m_ep[0][5] & !(sel && !wd[5]));
            end else begin
                ne[7:5] = 3'b000;
            end
            m_ep[k] = ne;
        end
    endtask

    task automatic idle_read(input logic [7:0] a);
        cycle(1'b0, a, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic fw_write(input logic [7:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, 2'd3, 7'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic token(input logic [1:0] tk, input logic [6:0] ta, input logic [3:0] te);
        cycle(1'b0, 8'h12, 8'h00, 1'b1, tk, ta, te, 1'b0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_dev = 0; m_act = 0; m_ep[0] = 0; m_ep[1] = 0; m_ep[2] = 0;
        rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        sie_tok_valid = 0; sie_tok_kind = 3; sie_tok_addr = 0; sie_tok_ep = 0;
        sie_ack_valid = 0; sie_ack_ep = 0; sie_activity = 0; sie_bus_reset = 0;
        // Dirty the design during reset; it must still come up cleared.
        @(negedge clk); bus_wr = 1; bus_addr = 8'h10; bus_wdata = 8'hFF; sie_activity = 1;
        repeat (3) @(negedge clk);
        bus_wr = 0; sie_activity = 0;
        rst_n = 1'b1;
        // R1: reset state.
        foreach (m_ep[i]) begin end
        for (int i = 0; i < 5; i++) begin
            logic [7:0] a;
            a = (i == 0) ? 8'h10 : (i == 1) ? 8'h11 : 8'(8'h12 + 2 * (i - 2));
            @(negedge clk); bus_addr = a; #1;
            check("R1", bus_rdata, 8'h00, $sformatf("reset read %0h", a));
        end
        check("R1", ep_mode, 12'h000, "reset ep_mode");
        check("R1", tok_accept, 1'b0, "reset tok_accept");

        // R4: disabled device ignores a matching address-0 token.
        token(2'd2, 7'd0, 4'd0);
        // R3: program address 5 with enable.
        fw_write(8'h10, 8'h85);
        idle_read(8'h10);
        // R4, R6: SETUP then IN to endpoint 0.
        token(2'd2, 7'd5, 4'd0);
        token(2'd1, 7'd5, 4'd0);
        idle_read(8'h12);
        // R7: wrong address, endpoint 3 and endpoint 1 leave flags alone.
        token(2'd0, 7'd6, 4'd0);
        token(2'd0, 7'd5, 4'd3);
        token(2'd0, 7'd5, 4'd1);
        token(2'd3, 7'd5, 4'd0);
        idle_read(8'h12);
        // R6: write 1 keeps, write 0 clears only that flag.
        fw_write(8'h12, 8'hFF);
        fw_write(8'h12, 8'h7A);
        idle_read(8'h12);
        // R6: set wins over a same-cycle clear.
        cycle(1'b1, 8'h12, 8'h00, 1'b1, 2'd0, 7'd5, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0);
        idle_read(8'h12);
        // R8, R10: upper bits of endpoint 1 ignore writes.
        fw_write(8'h14, 8'hFF);
        idle_read(8'h14);
        fw_write(8'h16, 8'hE9);
        idle_read(8'h16);
        // R9: handshake on endpoint 2, then out-of-range endpoint.
        cycle(1'b0, 8'h16, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b1, 4'd2, 1'b0, 1'b0);
        cycle(1'b0, 8'h16, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b1, 4'd7, 1'b0, 1'b0);
        idle_read(8'h16);
        cycle(1'b1, 8'h16, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b1, 4'd2, 1'b0, 1'b0);
        idle_read(8'h16);
        // R2: activity set, write 1 keeps, write 0 clears, set beats clear.
        cycle(1'b0, 8'h11, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0);
        fw_write(8'h11, 8'h01);
        fw_write(8'h11, 8'hFE);
        idle_read(8'h11);
        cycle(1'b1, 8'h11, 8'h00, 1'b0, 2'd3, 7'd0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0);
        idle_read(8'h11);
        // R11: unmapped write and read.
        fw_write(8'h13, 8'hFF);
        idle_read(8'h13);
        idle_read(8'h15);
        // R5: bus reset wins over a same-cycle address write.
        cycle(1'b1, 8'h10, 8'h85, 1'b0, 2'd3, 7'd0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1);
        idle_read(8'h10);
        token(2'd2, 7'd0, 4'd0);
        idle_read(8'h14);

        // Constrained random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a, wd;
            logic [2:0] pick;
            logic [6:0] ta;
            pick = 3'($urandom % 7);
            case (pick)
                3'd0: a = 8'h10; 3'd1: a = 8'h11; 3'd2: a = 8'h12;
                3'd3: a = 8'h14; 3'd4: a = 8'h16; 3'd5: a = 8'h13;
                default: a = 8'h20;
            endcase
            wd = 8'($urandom);
            if (a == 8'h10 && ($urandom % 4) != 0) wd[7] = 1'b1;
            ta = (($urandom % 2) == 0) ? m_dev[6:0] : 7'($urandom);
            cycle(($urandom % 10) < 3, a, wd, ($urandom % 2) == 0, 2'($urandom),
                  ta, 4'($urandom % 5), ($urandom % 4) == 0, 4'($urandom % 5),
                  ($urandom % 8) == 0, ($urandom % 100) == 0);
        end

        summary();
        $finish;
    end
endmodule